// File: doc/BRIEF.md
# Multiprocessor Interrupt Mask and Level Controller

This block collects interrupt requests for a system of up to four processors and turns them into one 4-bit priority level per processor. Level-sensitive device requests feed a shared bank that holds a mask. Software changes that mask only through write-one-to-set and write-one-to-clear words. A master bit in the mask blocks every device source at once. Unmasked device requests reach exactly one processor, the one named by a target register.

Each processor also has its own bank. Software raises and lowers that processor's soft interrupt bits by writing ones, and the processor's local timer request appears there as a fixed-level hard bit. For each processor the block drives the highest level among its active sources, or zero when none are active. Software reaches the registers through a word-addressed read/write port with combinational read data.

Word map (5-bit word address):
- Processor c has three words: c*4+0 reads its pending bits, c*4+1 clears soft bits, and c*4+2 sets soft bits.
- The shared bank uses word 16 for pending, 17 for the mask, 18 to unmask, 19 to mask, and 20 for the target.

Top module: `mp_irq_mask_ctrl`

## Requirements
- R1: After reset the mask reads 0xF07FFF80 (every implemented device source and the master bit 31 are masked). All soft bits are clear, the target reads 0, and no level is driven unless a timer request is high.
- R2: A one written to bit 16+x of a processor's set word (word c*4+2) raises soft level x, for x in 1 to 15. A one written to the same bit of its clear word (word c*4+1) lowers it. Bits 16 down to 0 of such writes have no effect, and other processors are unchanged.
- R3: A one written to a bit of word 19 masks that source, and a one written to word 18 unmasks it. Zero bits leave the mask unchanged, and bits that are not implemented always read 0.
- R4: While mask bit 31 is set, no device source contributes to any level, whatever the other mask bits hold.
- R5: Word 16 reads the device request inputs restricted to the implemented bits 7 to 22 and 28 to 30, independent of the mask.
- R6: Device bits map to levels as follows:
  - Slot bits 7 to 13 map to levels 2, 3, 5, 7, 9, 11 and 13.
  - Bit 14 (keyboard) and bit 15 (serial) map to 12.
  - Bit 16 (network) maps to 6, bit 17 (audio) to 13, bit 18 (disk) to 4, bit 19 (system timer) to 10, bit 20 (video) to 8, and bit 22 (floppy) to 11.
  - Bit 30 (module error) maps to 9.
  - Bit 21 (module interrupt), bit 28 (memory error) and bit 29 (write-buffer error) map to 15.
- R7: Device sources contribute only to the processor whose index word 20 holds. A write of a value not below the processor count leaves the target unchanged.
- R8: Each processor's level is the maximum over its unmasked routed device sources, its soft levels, and level 14 when its timer request is high. The timer request also reads as bit 14 of that processor's pending word.
- R9: Reads of the clear, set, unmask and mask words return 0. Writes to the pending words have no effect.
- R10: Reads of words outside the map, including processor banks beyond the processor count, return 0. Writes there change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access strobe for this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data |
| devReq | input | 32 | Level-sensitive device requests |
| cpuTimerReq | input | NUM_CPU | Per-processor timer request |
| cpuLevel | output | NUM_CPU*4 | Level per processor, processor c at bits c*4+3:c*4 |

## Verification
The bench sweeps a single device bit through every implemented position, which separates each entry of the level map and exposes swapped or missing entries. It then sets overlapping device, soft and timer sources, so that a wrong maximum can be told apart from a plain priority encoder. Moving the target between processors, and writing an out-of-range target, separates correct routing from broadcast routing. Masking with zero data, the master bit alone, low-half soft writes, and accesses to unused or read-only words show which writes a faulty decode lets through.

// File: rtl/imc_pkg.sv
`timescale 1ns/1ps
package imc_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 5;
  localparam int LVL_W     = 4;
  localparam int CPU_IDX_W = 2;
  localparam int MASTER_BIT = 31;
  localparam int SOFT_LO    = 17;
  localparam int TIMER_BIT  = 14;
  localparam logic [LVL_W-1:0] TIMER_LVL = 4'd14;

  // implemented device source bits
  localparam logic [DATA_W-1:0] SRC_IMPL  = 32'h707F_FF80;
  localparam logic [DATA_W-1:0] MASK_BITS = SRC_IMPL | (32'h1 << MASTER_BIT);
  localparam logic [DATA_W-1:0] SOFT_BITS = 32'hFFFE_0000;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_CPU_PEND,
    RD_GLB_PEND,
    RD_GLB_MASK,
    RD_TARGET
  } rdSel_e;

  typedef struct packed {
    logic                 softSet;
    logic                 softClr;
    logic                 maskSet;
    logic                 maskClr;
    logic                 tgtWr;
    logic [CPU_IDX_W-1:0] cpu;
    rdSel_e               rdSel;
  } ctrlStb_t;

  // level assigned to each device source bit
  function automatic logic [LVL_W-1:0] srcLevel(input int unsigned b);
    case (b)
      7:  return 4'd2;
      8:  return 4'd3;
      9:  return 4'd5;
      10: return 4'd7;
      11: return 4'd9;
      12: return 4'd11;
      13: return 4'd13;
      14, 15: return 4'd12;
      16: return 4'd6;
      17: return 4'd13;
      18: return 4'd4;
      19: return 4'd10;
      20: return 4'd8;
      21: return 4'd15;
      22: return 4'd11;
      28, 29: return 4'd15;
      30: return 4'd9;
      default: return 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/imc_ctrl.sv
`timescale 1ns/1ps
module imc_ctrl
  import imc_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStb_t          stb
);
  localparam logic [CPU_IDX_W:0] CPU_LIMIT = (CPU_IDX_W+1)'(NUM_CPU);

  logic isGlobal;
  logic [CPU_IDX_W-1:0] cpuField;
  logic [1:0] cpuWord;
  logic [2:0] glbWord;

  assign isGlobal = busAddr[4];
  assign cpuField = busAddr[3:2];
  assign cpuWord  = busAddr[1:0];
  assign glbWord  = busAddr[2:0];

  always_comb begin
    stb       = '0;
    stb.rdSel = RD_ZERO;
    if (busSel) begin
      if (!isGlobal) begin
        if ({1'b0, cpuField} < CPU_LIMIT) begin
          stb.cpu = cpuField;
          case (cpuWord)
            2'd0:    stb.rdSel   = RD_CPU_PEND;
            2'd1:    stb.softClr = busWr;
            2'd2:    stb.softSet = busWr;
            default: ;
          endcase
        end
      end else if (!busAddr[3]) begin
        case (glbWord)
          3'd0: stb.rdSel   = RD_GLB_PEND;
          3'd1: stb.rdSel   = RD_GLB_MASK;
          3'd2: stb.maskClr = busWr;
          3'd3: stb.maskSet = busWr;
          3'd4: begin
            stb.rdSel = RD_TARGET;
            stb.tgtWr = busWr;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/imc_datapath.sv
`timescale 1ns/1ps
module imc_datapath
  import imc_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctrlStb_t                       stb,
  input  logic [DATA_W-1:0]              wdata,
  input  logic [DATA_W-1:0]              devReq,
  input  logic [NUM_CPU-1:0]             cpuTimerReq,
  output logic [DATA_W-1:0]              rdata,
  output logic [NUM_CPU*LVL_W-1:0]       cpuLevel
);
  localparam logic [DATA_W-1:0] TGT_LIMIT = DATA_W'(NUM_CPU);

  logic [DATA_W-1:0]                 maskQ;
  logic [CPU_IDX_W-1:0]              tgtQ;
  logic [NUM_CPU-1:0][DATA_W-1:0]    softQ;
  logic [DATA_W-1:0]                 devPend;
  logic [DATA_W-1:0]                 devActive;
  logic [LVL_W-1:0]                  glbLvl;
  logic [DATA_W-1:0]                 cpuPend;

  // shared mask and target
  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= MASK_BITS;
      tgtQ  <= '0;
    end else begin
      if (stb.maskSet) maskQ <= maskQ | (wdata & MASK_BITS);
      else if (stb.maskClr) maskQ <= maskQ & ~(wdata & MASK_BITS);
      if (stb.tgtWr && (wdata < TGT_LIMIT)) tgtQ <= wdata[CPU_IDX_W-1:0];
    end
  end

  assign devPend   = devReq & SRC_IMPL;
  assign devActive = maskQ[MASTER_BIT] ? '0 : (devPend & ~maskQ);

  always_comb begin
    glbLvl = '0;
    for (int b = 0; b < DATA_W; b++) begin
      if (devActive[b] && (srcLevel(b) > glbLvl)) glbLvl = srcLevel(b);
    end
  end

  // per-processor soft bits and level
  for (genvar c = 0; c < NUM_CPU; c++) begin : gCpu
    logic hit;
    logic [LVL_W-1:0] softLvl;
    logic [LVL_W-1:0] lvlA;
    logic [LVL_W-1:0] lvlB;

    assign hit = (stb.cpu == CPU_IDX_W'(c));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        softQ[c] <= '0;
      end else if (hit && stb.softSet) begin
        softQ[c] <= softQ[c] | (wdata & SOFT_BITS);
      end else if (hit && stb.softClr) begin
        softQ[c] <= softQ[c] & ~(wdata & SOFT_BITS);
      end
    end

    always_comb begin
      softLvl = '0;
      for (int x = 1; x < 16; x++) begin
        if (softQ[c][16+x]) softLvl = LVL_W'(x);
      end
    end

    assign lvlA = (cpuTimerReq[c] && (TIMER_LVL > softLvl)) ? TIMER_LVL : softLvl;
    assign lvlB = ((tgtQ == CPU_IDX_W'(c)) && (glbLvl > lvlA)) ? glbLvl : lvlA;
    assign cpuLevel[c*LVL_W +: LVL_W] = lvlB;
  end

  always_comb begin
    cpuPend = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (stb.cpu == CPU_IDX_W'(c)) begin
        cpuPend = (softQ[c] & SOFT_BITS) | (DATA_W'(cpuTimerReq[c]) << TIMER_BIT);
      end
    end
  end

  always_comb begin
    case (stb.rdSel)
      RD_CPU_PEND: rdata = cpuPend;
      RD_GLB_PEND: rdata = devPend;
      RD_GLB_MASK: rdata = maskQ;
      RD_TARGET:   rdata = DATA_W'(tgtQ);
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/mp_irq_mask_ctrl.sv
`timescale 1ns/1ps
module mp_irq_mask_ctrl
  import imc_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busSel,
  input  logic                     busWr,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic [DATA_W-1:0]        busWdata,
  output logic [DATA_W-1:0]        busRdata,
  input  logic [DATA_W-1:0]        devReq,
  input  logic [NUM_CPU-1:0]       cpuTimerReq,
  output logic [NUM_CPU*LVL_W-1:0] cpuLevel
);
  ctrlStb_t stb;

  imc_ctrl #(.NUM_CPU(NUM_CPU)) uCtrl (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .stb    (stb)
  );

  imc_datapath #(.NUM_CPU(NUM_CPU)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wdata      (busWdata),
    .devReq     (devReq),
    .cpuTimerReq(cpuTimerReq),
    .rdata      (busRdata),
    .cpuLevel   (cpuLevel)
  );
endmodule

// File: rtl/imc_checker.sv
`timescale 1ns/1ps
module imc_checker
  import imc_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          busSel,
  input logic                          busWr,
  input logic [ADDR_W-1:0]             busAddr,
  input logic [DATA_W-1:0]             busWdata,
  input logic [DATA_W-1:0]             busRdata,
  input logic [NUM_CPU-1:0]            cpuTimerReq,
  input logic [NUM_CPU*LVL_W-1:0]      cpuLevel,
  input logic [DATA_W-1:0]             maskQ,
  input logic [CPU_IDX_W-1:0]          tgtQ,
  input logic [NUM_CPU-1:0][DATA_W-1:0] softQ
);
  logic anyWr;
  logic setWr;
  logic clrWr;
  assign anyWr = busSel && busWr;
  assign setWr = anyWr && (busAddr == 5'd19);
  assign clrWr = anyWr && (busAddr == 5'd18);

  p_mask_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    setWr |=> ((maskQ & $past(busWdata) & MASK_BITS) == ($past(busWdata) & MASK_BITS)));

  p_mask_clr_r3: assert property (@(posedge clk) disable iff (!rstN)
    clrWr |=> ((maskQ & $past(busWdata) & MASK_BITS) == '0));

  p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !anyWr |=> $stable(maskQ));

  p_soft_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !anyWr |=> $stable(softQ));

  p_port_read_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && ((busAddr == 5'd18) || (busAddr == 5'd19))) |-> (busRdata == '0));

  p_master_r4: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ[MASTER_BIT] && (softQ == '0) && (cpuTimerReq == '0)) |-> (cpuLevel == '0));

  for (genvar c = 0; c < NUM_CPU; c++) begin : gOff
    p_offtarget_r7: assert property (@(posedge clk) disable iff (!rstN)
      ((tgtQ != CPU_IDX_W'(c)) && (softQ[c] == '0) && !cpuTimerReq[c])
        |-> (cpuLevel[c*LVL_W +: LVL_W] == '0));
  end
endmodule

bind mp_irq_mask_ctrl imc_checker #(.NUM_CPU(NUM_CPU)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .busSel     (busSel),
  .busWr      (busWr),
  .busAddr    (busAddr),
  .busWdata   (busWdata),
  .busRdata   (busRdata),
  .cpuTimerReq(cpuTimerReq),
  .cpuLevel   (cpuLevel),
  .maskQ      (uDp.maskQ),
  .tgtQ       (uDp.tgtQ),
  .softQ      (uDp.softQ)
);

// File: tb/mp_irq_mask_ctrl_test.sv
`timescale 1ns/1ps
module mp_irq_mask_ctrl_test;
  localparam int NC = 4;
  localparam logic [31:0] IMPL = 32'h707F_FF80;
  localparam logic [31:0] MASKABLE = 32'hF07F_FF80;
  localparam logic [31:0] SOFTM = 32'hFFFE_0000;

  logic clk = 0;
  logic rstN = 0;
  logic busSel = 0;
  logic busWr = 0;
  logic [4:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] devReq = '0;
  logic [NC-1:0] cpuTimerReq = '0;
  logic [NC*4-1:0] cpuLevel;

  int checks = 0;
  int errors = 0;
  bit running = 0;
  bit done = 0;

  // behavioural model state
  logic [31:0] mMask;
  logic [31:0] mSoft [NC];
  int mTgt;

  always #10 clk = ~clk;

  mp_irq_mask_ctrl #(.NUM_CPU(NC)) uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .devReq(devReq),
    .cpuTimerReq(cpuTimerReq), .cpuLevel(cpuLevel)
  );

  function automatic int lvlOf(int b);
    int t [32] = '{0,0,0,0,0,0,0,2,3,5,7,9,11,13,12,12,6,13,4,10,8,15,11,0,0,0,0,0,15,15,9,0};
    return t[b];
  endfunction

  function automatic int expLevel(int c);
    int l = 0;
    if (!mMask[31] && (mTgt == c))
      for (int b = 0; b < 32; b++)
        if (devReq[b] && IMPL[b] && !mMask[b] && lvlOf(b) > l) l = lvlOf(b);
    for (int x = 1; x < 16; x++) if (mSoft[c][16+x] && x > l) l = x;
    if (cpuTimerReq[c] && l < 14) l = 14;
    return l;
  endfunction

  function automatic logic [31:0] expRead(int a);
    if (a < 16) begin
      if ((a / 4) < NC && (a % 4) == 0)
        return (mSoft[a/4] & SOFTM) | (32'(cpuTimerReq[a/4]) << 14);
      return 0;
    end
    if (a == 16) return devReq & IMPL;
    if (a == 17) return mMask;
    if (a == 20) return 32'(mTgt);
    return 0;
  endfunction

  task automatic modelReset();
    mMask = MASKABLE;
    mTgt = 0;
    for (int c = 0; c < NC; c++) mSoft[c] = '0;
  endtask

  task automatic modelWrite(int a, logic [31:0] d);
    if (a < 16) begin
      if ((a / 4) < NC) begin
        if ((a % 4) == 1) mSoft[a/4] = mSoft[a/4] & ~(d & SOFTM);
        if ((a % 4) == 2) mSoft[a/4] = mSoft[a/4] | (d & SOFTM);
      end
    end else if (a == 18) mMask = mMask & ~(d & MASKABLE);
    else if (a == 19) mMask = mMask | (d & MASKABLE);
    else if (a == 20 && d < NC) mTgt = int'(d);
  endtask

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison of every level output against the model
  always @(posedge clk) begin
    #15;
    if (running)
      for (int c = 0; c < NC; c++)
        check(int'(cpuLevel[c*4 +: 4]) == expLevel(c), "R8 level per clock",
              32'(cpuLevel[c*4 +: 4]), 32'(expLevel(c)));
  end

  task automatic busWrite(int a, logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = 5'(a); busWdata = d;
    @(posedge clk);
    #1;
    modelWrite(a, d);
    busSel = 0; busWr = 0;
  endtask

  task automatic busRead(int a, string tag);
    @(negedge clk);
    busSel = 1; busWr = 0; busAddr = 5'(a);
    #2;
    check(busRdata == expRead(a), tag, busRdata, expRead(a));
    busSel = 0;
  endtask

  task automatic chkLvl(int c, int e, string tag);
    @(negedge clk);
    #3;
    check(int'(cpuLevel[c*4 +: 4]) == e, tag, 32'(cpuLevel[c*4 +: 4]), 32'(e));
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    running = 1;

    // R1 reset state
    busRead(17, "R1 mask reset");
    check(expRead(17) == 32'hF07F_FF80, "R1 mask reset value", expRead(17), 32'hF07F_FF80);
    busRead(20, "R1 target reset");
    for (int c = 0; c < NC; c++) busRead(c*4, "R1 soft reset");
    chkLvl(0, 0, "R1 level reset");

    // R5 pending follows requests through the implemented bits only
    @(negedge clk) devReq = 32'hFFFF_FFFF;
    busRead(16, "R5 pending implemented");
    chkLvl(0, 0, "R4 all masked");
    @(negedge clk) devReq = 32'h0004_0000;
    busRead(16, "R5 pending single");

    // R3 unmask master and disk
    busWrite(18, 32'h8004_0000);
    busRead(17, "R3 mask after clear");
    chkLvl(0, 4, "R6 disk level");
    chkLvl(1, 0, "R7 non-target idle");

    // R3 zero write leaves the mask unchanged
    busWrite(19, 32'h0);
    busRead(17, "R3 zero mask write");
    busWrite(18, 32'hFFFF_FFFF);
    busRead(17, "R3 unimplemented bits zero");

    // R6 sweep every implemented bit
    for (int b = 0; b < 32; b++) begin
      @(negedge clk) devReq = 32'h1 << b;
      chkLvl(0, IMPL[b] ? lvlOf(b) : 0, "R6 source map");
    end

    // R8 overlapping sources: maximum wins
    @(negedge clk) devReq = (32'h1 << 18) | (32'h1 << 19) | (32'h1 << 7);
    chkLvl(0, 10, "R8 device maximum");

    // R7 routing
    busWrite(20, 2);
    chkLvl(2, 10, "R7 target receives");
    chkLvl(0, 0, "R7 old target idle");
    busWrite(20, 5);
    busRead(20, "R7 out-of-range target ignored");
    chkLvl(2, 10, "R7 target kept");

    // R4 master bit alone
    busWrite(19, 32'h8000_0000);
    chkLvl(2, 0, "R4 master mask");
    busRead(16, "R5 pending under master mask");
    busWrite(18, 32'h8000_0000);
    chkLvl(2, 10, "R4 master unmask");
    busWrite(19, 32'h0008_0000);
    chkLvl(2, 4, "R3 single mask");

    // R2 soft bits
    busWrite(1*4+2, (32'h1 << 21) | 32'h0001_FFFF);
    busRead(1*4, "R2 soft set low half ignored");
    chkLvl(1, 5, "R2 soft level");
    chkLvl(3, 0, "R2 other cpu untouched");
    busWrite(1*4+2, 32'h1 << 28);
    chkLvl(1, 12, "R2 soft maximum");
    busWrite(1*4+1, 32'h1 << 28);
    chkLvl(1, 5, "R2 soft clear");
    busWrite(2*4+2, 32'h1 << 31);
    chkLvl(2, 15, "R8 soft over device");

    // R8 timer
    @(negedge clk) cpuTimerReq = 4'b1000;
    chkLvl(3, 14, "R8 timer level");
    busRead(3*4, "R8 timer pending bit");
    busWrite(3*4+2, 32'h1 << 20);
    chkLvl(3, 14, "R8 timer over soft");
    busWrite(3*4+2, 32'h1 << 31);
    chkLvl(3, 15, "R8 soft over timer");

    // R9 write-only words read zero, pending writes ignored
    busRead(18, "R9 unmask word reads zero");
    busRead(19, "R9 mask word reads zero");
    busRead(1*4+1, "R9 clear word reads zero");
    busRead(1*4+2, "R9 set word reads zero");
    busWrite(1*4, 32'hFFFF_FFFF);
    busRead(1*4, "R9 pending write ignored");
    busWrite(16, 32'hFFFF_FFFF);
    busRead(17, "R9 global pending write ignored");

    // R10 unmapped words
    busWrite(23, 32'hFFFF_FFFF);
    busWrite(1*4+3, 32'hFFFF_FFFF);
    busRead(23, "R10 unmapped read zero");
    busRead(1*4+3, "R10 gap read zero");
    busRead(17, "R10 mask untouched");
    busRead(1*4, "R10 soft untouched");

    repeat (3) @(posedge clk);
    running = 0;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule